// File: doc/BRIEF.md
# Dot-Matrix Refresh Controller with Dimming and Blanking

This block refreshes a four-character display built from 5-column by 7-row LED dot matrices. It steps through every column of every character in turn and, for each column, asks an external glyph lookup for the seven row dots of the stored character code. Where the cursor view is selected and a digit has its cursor flag set, it sends an all-lit pattern in place of the glyph. A single row-enable output turns the row drivers on and off, so brightness dimming and blanking both act through that one output.

Each column slot lasts a fixed number of sub-periods, eight by default. A 3-bit brightness field sets how many of those sub-periods the rows are lit. Level 0 is the brightest. Level 7 is the dimmest, but still lights one sub-period. An external blank input and a master-blank control bit can each force the rows off. A per-digit exemption keeps a chosen digit visible through either kind of blanking. An extended-functions-disable bit makes the block ignore the cursor flags and the exemption flags.

The sequencer is a small state machine with three states. `ST_IDLE` holds the outputs quiet after reset. `ST_LIT` is a sub-period in which the rows are allowed on. `ST_DARK` is a sub-period that brightness dimming has turned off. There are four transitions:
- `ST_IDLE` to `ST_LIT` on the first clock after reset.
- `ST_LIT` or `ST_DARK` to `ST_LIT` when the next sub-period index is below the on-count (8 minus brightness).
- `ST_LIT` to `ST_DARK` when the next sub-period index reaches the on-count.
- `ST_DARK` to `ST_DARK` for every remaining sub-period of the slot.

Top module: `dmx_scan_ctrl`

## Requirements
- R1: While `rst_n` is low, and until the first rising clock edge after it goes high, `col_sel` is all zeros and `row_en` is 0. That first edge starts the scan at digit 0, column 0, sub-period 0, in a lit sub-period.
- R2: Each column slot lasts exactly 8 clock cycles. Slots follow the order digit 0 to 3 and, within a digit, column 0 to 4, then repeat. During scanning `col_sel` is one-hot with bit index digit*5+column.
- R3: `glyph_code` equals the 7-bit code of the current digit, which is `char_codes[7*d+6:7*d]`. `glyph_col` equals the current column. When no cursor applies, `row_data` equals `glyph_rows` in the same cycle.
- R4: When `cursor_show` is 1 and `cursor_en[d]` is 1 for the current digit d, `row_data` is 7'h7F.
- R5: The rows are allowed on only in the first (8 - `bright`) sub-periods of each slot. `bright` is sampled at the clock edge that begins each sub-period. Level 0 lights all 8 sub-periods and level 7 lights only sub-period 0.
- R6: When `blank_in` is 1 or `master_blank` is 1, `row_en` is 0 in that same cycle, unless the current digit is exempt.
- R7: A digit with `blank_exempt[d]` set to 1 ignores `blank_in` and `master_blank`, but is still dimmed by `bright`.
- R8: When `ext_func_dis` is 1, `cursor_en` and `blank_exempt` have no effect. No cursor pattern is shown and no digit is exempt from blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_codes | input | 28 | Four 7-bit character codes; digit d occupies bits 7d+6..7d |
| cursor_en | input | 4 | Per-digit cursor flag |
| blank_exempt | input | 4 | Per-digit exemption from blanking |
| bright | input | 3 | Dimming level, 0 brightest, 7 dimmest |
| master_blank | input | 1 | Control-register blank, 1 = blank |
| ext_func_dis | input | 1 | 1 = ignore the cursor and exemption flags |
| blank_in | input | 1 | External blank, 1 = blank (pulse it to dim) |
| cursor_show | input | 1 | 1 = show the cursor pattern on flagged digits |
| glyph_rows | input | 7 | Row dots returned by the external glyph lookup |
| glyph_code | output | 7 | Character code presented to the glyph lookup |
| glyph_col | output | 3 | Column index presented to the glyph lookup |
| col_sel | output | 20 | One-hot column select, bit digit*5+column |
| row_data | output | 7 | Row dots for the selected column |
| row_en | output | 1 | Row driver enable: dimming and blanking gate |

## Verification
Three things can decide a single cycle's `row_en` together. The first is brightness dimming, which turns a sub-period dark. The second is blanking from either source. The third is the per-digit exemption, which can override blanking but not dimming.

The bench provokes these collisions in two ways. It pulses `blank_in` on a period that does not divide the slot length, while the brightness level is mid-range, so blank pulses fall on both lit and dark sub-periods. It also applies master blank with some digits exempt, both with and without `ext_func_dis`. In the same runs the cursor view is on, so a cursor substitution and a blanked or dimmed cycle fall on the same digit. A behavioural reference model predicts `row_en`, `row_data` and `col_sel` on every clock, and each mismatch is tagged with the requirement responsible for that cycle's outcome.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LIT  = 2'd1,
        ST_DARK = 2'd2
    } scan_state_t;
endpackage

// File: rtl/dmx_scan_seq.sv
module dmx_scan_seq
    import dmx_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int COLS   = 5,
    parameter int SUBS   = 8,
    localparam int DW    = $clog2(DIGITS),
    localparam int CW    = $clog2(COLS),
    localparam int SW    = $clog2(SUBS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] bright,
    output scan_state_t   state,
    output logic [DW-1:0] digit,
    output logic [CW-1:0] col,
    output logic [SW-1:0] sub
);
    scan_state_t   state_n;
    logic [DW-1:0] digit_n;
    logic [CW-1:0] col_n;
    logic [SW-1:0] sub_n;
    logic [SW:0]   on_cnt;

    assign on_cnt = (SW+1)'(SUBS) - {1'b0, bright};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            digit <= '0;
            col   <= '0;
            sub   <= '0;
        end else begin
            state <= state_n;
            digit <= digit_n;
            col   <= col_n;
            sub   <= sub_n;
        end
    end

    always_comb begin
        state_n = state;
        digit_n = digit;
        col_n   = col;
        sub_n   = sub;
        unique case (state)
            ST_IDLE: state_n = ST_LIT;
            ST_LIT, ST_DARK: begin
                if (sub == SW'(SUBS-1)) begin
                    sub_n = '0;
                    if (col == CW'(COLS-1)) begin
                        col_n   = '0;
                        digit_n = (digit == DW'(DIGITS-1)) ? '0 : digit + 1'b1;
                    end else begin
                        col_n = col + 1'b1;
                    end
                end else begin
                    sub_n = sub + 1'b1;
                end
                state_n = ({1'b0, sub_n} < on_cnt) ? ST_LIT : ST_DARK;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    AST_SUB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && sub == SW'(SUBS-1)) |=> (sub == '0)); // R2
    AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && sub != SW'(SUBS-1)) |=> $stable(col) && $stable(digit)); // R2
    AST_SLOT_STARTS_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && sub == '0) |-> (state == ST_LIT)); // R5
endmodule

// File: rtl/dmx_pixel_mux.sv
module dmx_pixel_mux #(
    parameter int DIGITS = 4,
    parameter int COLS   = 5,
    parameter int ROWS   = 7,
    parameter int CODE_W = 7,
    localparam int DW    = $clog2(DIGITS),
    localparam int CW    = $clog2(COLS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DIGITS*CODE_W-1:0] char_codes,
    input  logic [DIGITS-1:0]        cursor_en,
    input  logic                     cursor_show,
    input  logic                     ext_func_dis,
    input  logic [DW-1:0]            digit,
    input  logic [CW-1:0]            col,
    input  logic [ROWS-1:0]          glyph_rows,
    output logic [CODE_W-1:0]        glyph_code,
    output logic [CW-1:0]            glyph_col,
    output logic [ROWS-1:0]          row_data
);
    logic cur_flag;
    logic use_cursor;

    always_comb begin
        glyph_code = '0;
        cur_flag   = 1'b0;
        for (int i = 0; i < DIGITS; i++) begin
            if (DW'(i) == digit) begin
                glyph_code = char_codes[i*CODE_W +: CODE_W];
                cur_flag   = cursor_en[i];
            end
        end
    end

    assign glyph_col  = col;
    assign use_cursor = cursor_show && cur_flag && !ext_func_dis;
    assign row_data   = use_cursor ? '1 : glyph_rows;

    AST_CURSOR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cursor_show && cur_flag && !ext_func_dis) |-> (&row_data)); // R4
    AST_GLYPH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cursor_show || ext_func_dis) |-> (row_data == glyph_rows)); // R3
endmodule

// File: rtl/dmx_row_gate.sv
module dmx_row_gate
    import dmx_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int DW    = $clog2(DIGITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scan_state_t       state,
    input  logic [DW-1:0]     digit,
    input  logic [DIGITS-1:0] blank_exempt,
    input  logic              blank_in,
    input  logic              master_blank,
    input  logic              ext_func_dis,
    output logic              row_en
);
    logic exempt_bit;
    logic blank_req;

    always_comb begin
        exempt_bit = 1'b0;
        for (int i = 0; i < DIGITS; i++) begin
            if (DW'(i) == digit) exempt_bit = blank_exempt[i];
        end
    end

    assign blank_req = (blank_in || master_blank) && !(exempt_bit && !ext_func_dis);
    assign row_en    = (state == ST_LIT) && !blank_req;

    AST_DARK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LIT) |-> !row_en); // R5
    AST_EFD_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_func_dis && (blank_in || master_blank)) |-> !row_en); // R8
endmodule

// File: rtl/dmx_scan_ctrl.sv
module dmx_scan_ctrl
    import dmx_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int COLS   = 5,
    parameter int ROWS   = 7,
    parameter int CODE_W = 7,
    parameter int BR_W   = 3,
    localparam int SUBS  = 1 << BR_W,
    localparam int DW    = $clog2(DIGITS),
    localparam int CW    = $clog2(COLS),
    localparam int NSEL  = DIGITS * COLS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DIGITS*CODE_W-1:0] char_codes,
    input  logic [DIGITS-1:0]        cursor_en,
    input  logic [DIGITS-1:0]        blank_exempt,
    input  logic [BR_W-1:0]          bright,
    input  logic                     master_blank,
    input  logic                     ext_func_dis,
    input  logic                     blank_in,
    input  logic                     cursor_show,
    input  logic [ROWS-1:0]          glyph_rows,
    output logic [CODE_W-1:0]        glyph_code,
    output logic [CW-1:0]            glyph_col,
    output logic [NSEL-1:0]          col_sel,
    output logic [ROWS-1:0]          row_data,
    output logic                     row_en
);
    scan_state_t     state;
    logic [DW-1:0]   digit;
    logic [CW-1:0]   col;
    logic [BR_W-1:0] sub;

    dmx_scan_seq #(.DIGITS(DIGITS), .COLS(COLS), .SUBS(SUBS)) u_seq (
        .clk(clk), .rst_n(rst_n), .bright(bright),
        .state(state), .digit(digit), .col(col), .sub(sub)
    );

    dmx_pixel_mux #(.DIGITS(DIGITS), .COLS(COLS), .ROWS(ROWS), .CODE_W(CODE_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .char_codes(char_codes), .cursor_en(cursor_en),
        .cursor_show(cursor_show), .ext_func_dis(ext_func_dis),
        .digit(digit), .col(col), .glyph_rows(glyph_rows),
        .glyph_code(glyph_code), .glyph_col(glyph_col), .row_data(row_data)
    );

    dmx_row_gate #(.DIGITS(DIGITS)) u_gate (
        .clk(clk), .rst_n(rst_n), .state(state), .digit(digit),
        .blank_exempt(blank_exempt), .blank_in(blank_in),
        .master_blank(master_blank), .ext_func_dis(ext_func_dis), .row_en(row_en)
    );

    always_comb begin
        col_sel = '0;
        if (state != ST_IDLE) begin
            for (int d = 0; d < DIGITS; d++) begin
                for (int c = 0; c < COLS; c++) begin
                    if (DW'(d) == digit && CW'(c) == col) col_sel[d*COLS + c] = 1'b1;
                end
            end
        end
    end

    AST_COLSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> $onehot(col_sel)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (col_sel == '0 && !row_en)); // R1
    AST_EXEMPT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LIT && !ext_func_dis && blank_exempt[digit]) |-> row_en); // R7
endmodule

// File: tb/dmx_scan_ctrl_test.sv
`timescale 1ns/1ps
module dmx_scan_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] char_codes = '0;
    logic [3:0]  cursor_en = '0;
    logic [3:0]  blank_exempt = '0;
    logic [2:0]  bright = '0;
    logic        master_blank = 1'b0;
    logic        ext_func_dis = 1'b0;
    logic        blank_in = 1'b0;
    logic        cursor_show = 1'b0;
    logic [6:0]  glyph_rows;
    logic [6:0]  glyph_code;
    logic [2:0]  glyph_col;
    logic [19:0] col_sel;
    logic [6:0]  row_data;
    logic        row_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [6:0] glyph_fn(input logic [6:0] code, input logic [2:0] c);
        return 7'((int'(code) * 3) ^ (int'(c) * 37) ^ 'h15);
    endfunction

    assign glyph_rows = glyph_fn(glyph_code, glyph_col);

    dmx_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .char_codes(char_codes), .cursor_en(cursor_en),
        .blank_exempt(blank_exempt), .bright(bright), .master_blank(master_blank),
        .ext_func_dis(ext_func_dis), .blank_in(blank_in), .cursor_show(cursor_show),
        .glyph_rows(glyph_rows), .glyph_code(glyph_code), .glyph_col(glyph_col),
        .col_sel(col_sel), .row_data(row_data), .row_en(row_en)
    );

    // Behavioural reference model, advanced at each rising edge
    bit m_started = 0;
    int m_digit = 0, m_col = 0, m_sub = 0;
    bit m_lit = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 0; m_digit = 0; m_col = 0; m_sub = 0; m_lit = 0;
        end else if (!m_started) begin
            m_started = 1; m_lit = 1;
        end else begin
            m_sub++;
            if (m_sub == 8) begin
                m_sub = 0; m_col++;
                if (m_col == 5) begin m_col = 0; m_digit = (m_digit + 1) % 4; end
            end
            m_lit = (m_sub < 8 - int'(bright));
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!done) begin
            logic [6:0]  e_code;
            logic [19:0] e_sel;
            logic [6:0]  e_rows;
            bit exempt, blank, cur, e_en;
            string rtag;
            e_code = char_codes[m_digit*7 +: 7];
            e_sel  = m_started ? (20'd1 << (m_digit*5 + m_col)) : 20'd0;
            exempt = blank_exempt[m_digit] && !ext_func_dis;
            blank  = (blank_in || master_blank) && !exempt;
            cur    = cursor_show && cursor_en[m_digit] && !ext_func_dis;
            e_rows = cur ? 7'h7F : glyph_fn(e_code, 3'(m_col));
            e_en   = m_started && m_lit && !blank;
            if (!rst_n || !m_started) begin
                chk("R1", "col_sel in reset", 32'(col_sel), 32'(e_sel));
                chk("R1", "row_en in reset", 32'(row_en), 32'(e_en));
            end else begin
                chk("R2", "col_sel", 32'(col_sel), 32'(e_sel));
                chk("R3", "glyph_code", 32'(glyph_code), 32'(e_code));
                chk("R3", "glyph_col", 32'(glyph_col), 32'(m_col));
                chk(cur ? "R4" : (ext_func_dis && cursor_show) ? "R8" : "R3",
                    "row_data", 32'(row_data), 32'(e_rows));
                if (ext_func_dis && (blank_in || master_blank)) rtag = "R8";
                else if (exempt && (blank_in || master_blank)) rtag = "R7";
                else if (blank) rtag = "R6";
                else rtag = "R5";
                chk(rtag, "row_en", 32'(row_en), 32'(e_en));
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_up();
    end

    initial begin
        char_codes = {7'h44, 7'h43, 7'h42, 7'h41};
        run(3);
        rst_n = 1'b1;
        run(200);                                   // R2 R3 full brightness
        bright = 3'd3; run(160);                    // R5 mid level
        bright = 3'd7; run(160);                    // R5 dimmest, one sub-period
        for (int i = 0; i < 80; i++) begin bright = 3'(i / 5); run(1); end
        bright = 3'd0;
        cursor_show = 1'b1; cursor_en = 4'b0101; run(160);   // R4
        for (int i = 0; i < 60; i++) begin cursor_show = (i % 3 != 0); run(1); end
        bright = 3'd2;
        for (int i = 0; i < 200; i++) begin blank_in = (i % 3 == 0); run(1); end  // R6 pulsed dim
        blank_in = 1'b0;
        master_blank = 1'b1; blank_exempt = 4'b0011; run(160);                    // R6 R7
        master_blank = 1'b0; blank_in = 1'b1; blank_exempt = 4'b1000; run(160);   // R7
        ext_func_dis = 1'b1; blank_exempt = 4'b1111; cursor_en = 4'b1111;
        master_blank = 1'b1; run(160);                                            // R8
        master_blank = 1'b0; blank_in = 1'b0; run(160);                           // R8 cursor ignored
        ext_func_dis = 1'b0; char_codes = {7'h7F, 7'h00, 7'h20, 7'h5A}; run(100);
        rst_n = 1'b0; run(2);                                                     // R1 mid-run reset
        rst_n = 1'b1; run(60);
        finish_up();
    end
endmodule